// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block draws into a linear frame buffer through a single memory port. Software programs a source point, a destination point, a size, a fill colour, per-side line pitches and a base address through a small register port. It then writes a control word with the start bit set. The engine walks the rectangle one pixel at a time. For a fill it writes the colour to every destination pixel. For a copy it reads each source pixel and then writes it to the matching destination pixel.

For overlapping copies, software picks the walk direction. When the source lies above the destination, or on the same row and to its left, software loads the bottom-right corners and sets the reverse bit. The engine then counts both coordinates down from those corners. A busy flag on a pin and in a status register tells software when the operation has finished.

Each pixel is one memory word of DW bits. The memory request side is a valid/ready channel. The engine raises `mem_valid` with address, direction and write data, and holds all of them unchanged until `mem_ready` is sampled high. Read data comes back on `mem_rvalid`/`mem_rdata` and cannot be stalled. The engine has at most one request outstanding at a time.

Top module: `blit_engine`

## Requirements
- R1: After reset the engine is idle with busy low and no memory request, and every register reads back as zero.
- R2: Register map by word address: 0 source point, 1 destination point, 2 size, 3 control, 4 colour, 5 pitch, 6 base, 7 status. Points and sizes carry x (or width) in bits 31:16 and y (or height) in bits 15:0. The pitch register holds the destination bytes per line in bits 31:16 and the source bytes per line in bits 15:0. Pixel (x,y) lives at byte address base + y*pitch + x*4.
- R3: A control write with bit 31 set and command 1 in bits 19:16 starts a fill. The fill issues exactly one write of the colour register per destination pixel and no reads.
- R4: Command 0 starts a copy. Every pixel is read at its source address and then written with the returned word at its destination. Pixels are visited row by row with y increasing, and within a row with x increasing.
- R5: With control bit 27 set, both x and y count down from the loaded points, still with x as the inner loop.
- R6: Control bits 15:0 are stored and read back unchanged. Bits 31:16 read back as zero.
- R7: Writes to any register while busy is high have no effect, including a second start.
- R8: Busy rises in the cycle after the start write is accepted. It falls in the cycle after the final write request is accepted.
- R9: Bit 3 of the status register equals busy.
- R10: A start is ignored when the command is neither 0 nor 1, or when the width or height is zero.
- R11: After a read request is accepted, no further request is raised until the read data has returned.
- R12: While `mem_valid` is high and `mem_ready` is low, the request address, direction and data are held stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| busy | output | 1 | Operation in progress |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | 32 | Byte address of the pixel word |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench goes after overlapping copies in all three placements: destination below-right, destination above-left, and the same row with a rightward shift. A design that walked in the wrong direction, or decremented only one axis in reverse mode, would smear source pixels into the result, and the final memory image would differ. It also targets a single-pixel rectangle and random stalls on the ready line. An engine that dropped a request under back-pressure, or issued the next request before read data returned, would break the per-cycle request comparison.

Writes and starts issued while busy, starts with an unknown command, and starts with a zero dimension are also exercised. A design that latched registers during an operation would read back the wrong colour. A design that launched on a bad start would raise busy when the model expects it low.

// File: rtl/blit_pkg.sv
package blit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD,
    ST_RWAIT,
    ST_WR
  } blit_state_t;

  localparam logic [2:0] RA_SRC   = 3'd0;
  localparam logic [2:0] RA_DST   = 3'd1;
  localparam logic [2:0] RA_SIZE  = 3'd2;
  localparam logic [2:0] RA_CTRL  = 3'd3;
  localparam logic [2:0] RA_COLOR = 3'd4;
  localparam logic [2:0] RA_PITCH = 3'd5;
  localparam logic [2:0] RA_BASE  = 3'd6;
  localparam logic [2:0] RA_STAT  = 3'd7;

  localparam logic [3:0] OP_COPY = 4'd0;
  localparam logic [3:0] OP_FILL = 4'd1;

  localparam int STAT_BUSY = 3;

endpackage

// File: rtl/rect_walk.sv
module rect_walk #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  output logic [CW-1:0] off_x,
  output logic [CW-1:0] off_y,
  output logic          last
);

  logic row_end;

  assign row_end = (off_x == width - CW'(1));
  assign last    = row_end && (off_y == height - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      off_x <= '0;
      off_y <= '0;
    end else if (step) begin
      if (row_end) begin
        off_x <= '0;
        off_y <= off_y + CW'(1);
      end else begin
        off_x <= off_x + CW'(1);
      end
    end
  end

endmodule

// File: rtl/pix_addr.sv
module pix_addr #(
  parameter int CW  = 16,
  parameter int AW  = 32,
  parameter int BPP = 4
) (
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [CW-1:0] off_x,
  input  logic [CW-1:0] off_y,
  input  logic          rev,
  input  logic [CW-1:0] pitch,
  output logic [AW-1:0] addr
);

  logic [CW-1:0] px;
  logic [CW-1:0] py;

  always_comb begin
    px   = rev ? (org_x - off_x) : (org_x + off_x);
    py   = rev ? (org_y - off_y) : (org_y + off_y);
    addr = base + AW'(py) * AW'(pitch) + AW'(px) * AW'(BPP);
  end

endmodule

// File: rtl/blit_engine.sv
module blit_engine
  import blit_pkg::*;
#(
  parameter int CW = 16,
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [2*CW-1:0] reg_wdata,
  output logic [2*CW-1:0] reg_rdata,
  output logic            busy,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata
);

  localparam int RW      = 2 * CW;
  localparam int BPP     = DW / 8;
  localparam int GO_BIT  = RW - 1;
  localparam int REV_BIT = CW + 11;
  localparam int OP_LSB  = CW;

  blit_state_t   st_q;
  logic [RW-1:0] src_q, dst_q, size_q, pitch_q;
  logic [CW-1:0] ctl_lo_q;
  logic [DW-1:0] color_q, data_q;
  logic [AW-1:0] base_q;
  logic          fill_q, rev_q;

  logic [3:0]    op;
  logic          go, adv, last_px;
  logic [CW-1:0] off_x, off_y;
  logic [AW-1:0] side_addr [2];

  assign op   = reg_wdata[OP_LSB +: 4];
  assign busy = (st_q != ST_IDLE);
  assign go   = reg_we && (reg_addr == RA_CTRL) && !busy && reg_wdata[GO_BIT]
                && (op == OP_COPY || op == OP_FILL)
                && (size_q[RW-1:CW] != '0) && (size_q[CW-1:0] != '0);
  assign adv  = (st_q == ST_WR) && mem_ready && !last_px;

  rect_walk #(.CW(CW)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (go),
    .step   (adv),
    .width  (size_q[RW-1:CW]),
    .height (size_q[CW-1:0]),
    .off_x  (off_x),
    .off_y  (off_y),
    .last   (last_px)
  );

  // side 0 = source, side 1 = destination
  for (genvar g = 0; g < 2; g++) begin : g_side
    logic [RW-1:0] pt;
    assign pt = (g == 0) ? src_q : dst_q;
    pix_addr #(.CW(CW), .AW(AW), .BPP(BPP)) u_addr (
      .base  (base_q),
      .org_x (pt[RW-1:CW]),
      .org_y (pt[CW-1:0]),
      .off_x (off_x),
      .off_y (off_y),
      .rev   (rev_q),
      .pitch ((g == 0) ? pitch_q[CW-1:0] : pitch_q[RW-1:CW]),
      .addr  (side_addr[g])
    );
  end

  assign mem_valid = (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_we    = (st_q == ST_WR);
  assign mem_addr  = (st_q == ST_WR) ? side_addr[1] : side_addr[0];
  assign mem_wdata = fill_q ? color_q : data_q;

  // register file, frozen while an operation runs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q    <= '0;
      dst_q    <= '0;
      size_q   <= '0;
      ctl_lo_q <= '0;
      color_q  <= '0;
      pitch_q  <= '0;
      base_q   <= '0;
    end else if (reg_we && !busy) begin
      case (reg_addr)
        RA_SRC:   src_q    <= reg_wdata;
        RA_DST:   dst_q    <= reg_wdata;
        RA_SIZE:  size_q   <= reg_wdata;
        RA_CTRL:  ctl_lo_q <= reg_wdata[CW-1:0];
        RA_COLOR: color_q  <= DW'(reg_wdata);
        RA_PITCH: pitch_q  <= reg_wdata;
        RA_BASE:  base_q   <= AW'(reg_wdata);
        default:  ;
      endcase
    end
  end

  // pixel sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fill_q <= 1'b0;
      rev_q  <= 1'b0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (go) begin
          fill_q <= (op == OP_FILL);
          rev_q  <= reg_wdata[REV_BIT];
          st_q   <= (op == OP_FILL) ? ST_WR : ST_RD;
        end
        ST_RD: if (mem_ready) st_q <= ST_RWAIT;
        ST_RWAIT: if (mem_rvalid) begin
          data_q <= mem_rdata;
          st_q   <= ST_WR;
        end
        ST_WR: if (mem_ready) begin
          if (last_px)     st_q <= ST_IDLE;
          else if (fill_q) st_q <= ST_WR;
          else             st_q <= ST_RD;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SRC:   reg_rdata = src_q;
      RA_DST:   reg_rdata = dst_q;
      RA_SIZE:  reg_rdata = size_q;
      RA_CTRL:  reg_rdata[CW-1:0] = ctl_lo_q;
      RA_COLOR: reg_rdata = RW'(color_q);
      RA_PITCH: reg_rdata = pitch_q;
      RA_BASE:  reg_rdata = RW'(base_q);
      default:  reg_rdata[STAT_BUSY] = busy;
    endcase
  end

endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
  import blit_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic          go_bit,
  input logic          stat_bit,
  input logic          busy,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata
);

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_single_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !mem_we |=> !mem_valid);

  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == RA_CTRL && go_bit));

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_valid && mem_ready && mem_we));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid);

  assert_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == RA_STAT |-> stat_bit == busy);

endmodule

bind blit_engine blit_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .go_bit    (reg_wdata[2*CW-1]),
  .stat_bit  (reg_rdata[3]),
  .busy      (busy),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/blit_engine_test.sv
module blit_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        busy;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'd0;

  always #4 clk = ~clk;

  blit_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } op_t;

  int          errors = 0;
  int          checks = 0;
  logic [31:0] mem     [0:1023];
  logic [31:0] ref_mem [0:1023];
  op_t         exp_q[$];
  logic [31:0] m_src = 0, m_dst = 0, m_size = 0, m_color = 0, m_pitch = 0, m_base = 0;
  logic [15:0] m_ctl = 0;
  bit          exp_busy = 0;
  bit          rd_pend = 0;
  logic [31:0] rd_data = 0;
  bit          hold_pend = 0;
  logic [31:0] hold_addr = 0;
  logic [15:0] lfsr = 16'hACE1;
  string       cur_tag = "R3";
  bit          done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference: enqueue the request stream an operation must produce
  task automatic build(input logic [31:0] ctl);
    int  w, h, sx, sy, dx, dy;
    bit  rev, fill;
    logic [31:0] sa, da;
    w    = int'(m_size[31:16]);
    h    = int'(m_size[15:0]);
    rev  = ctl[27];
    fill = (ctl[19:16] == 4'd1);
    cur_tag = fill ? "R3" : (rev ? "R5" : "R4");
    for (int j = 0; j < h; j++) begin
      for (int i = 0; i < w; i++) begin
        sx = rev ? int'(m_src[31:16]) - i : int'(m_src[31:16]) + i;
        sy = rev ? int'(m_src[15:0]) - j : int'(m_src[15:0]) + j;
        dx = rev ? int'(m_dst[31:16]) - i : int'(m_dst[31:16]) + i;
        dy = rev ? int'(m_dst[15:0]) - j : int'(m_dst[15:0]) + j;
        sa = m_base + 32'(sy) * {16'd0, m_pitch[15:0]} + 32'(sx) * 4;
        da = m_base + 32'(dy) * {16'd0, m_pitch[31:16]} + 32'(dx) * 4;
        if (fill) begin
          exp_q.push_back('{1'b1, da, m_color});
          ref_mem[da[11:2]] = m_color;
        end else begin
          exp_q.push_back('{1'b0, sa, 32'd0});
          exp_q.push_back('{1'b1, da, ref_mem[sa[11:2]]});
          ref_mem[da[11:2]] = ref_mem[sa[11:2]];
        end
      end
    end
    exp_busy = 1;
  endtask

  task automatic model_write(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: m_src = d;
      3'd1: m_dst = d;
      3'd2: m_size = d;
      3'd3: begin
        m_ctl = d[15:0];
        if (d[31] && (d[19:16] <= 4'd1) && m_size[31:16] != 0 && m_size[15:0] != 0)
          build(d);
      end
      3'd4: m_color = d;
      3'd5: m_pitch = d;
      3'd6: m_base = d;
      default: ;
    endcase
  endtask

  // per-cycle model: memory responder, request compare, busy compare
  always @(negedge clk) begin
    bit  cur_busy;
    op_t e;
    if (rst_n && !done) begin
      cur_busy = exp_busy;
      chk(busy === exp_busy, "R8", "busy", 32'(busy), 32'(exp_busy));
      if (hold_pend)
        chk(mem_valid && mem_addr === hold_addr, "R12", "held request", mem_addr, hold_addr);
      if (rd_pend)
        chk(!mem_valid, "R11", "request while read outstanding", 32'(mem_valid), 0);
      mem_rvalid = rd_pend;
      mem_rdata  = rd_pend ? rd_data : 32'd0;
      rd_pend    = 0;
      lfsr       = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready  = (lfsr[1:0] != 2'b00);
      hold_pend  = mem_valid && !mem_ready;
      hold_addr  = mem_addr;
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, cur_tag, "unexpected request", mem_addr, 0);
        end else begin
          e = exp_q.pop_front();
          chk(mem_we === e.we, cur_tag, "request direction", 32'(mem_we), 32'(e.we));
          chk(mem_addr === e.addr, cur_tag, "request address", mem_addr, e.addr);
          if (e.we) begin
            chk(mem_wdata === e.data, cur_tag, "write data", mem_wdata, e.data);
            mem[mem_addr[11:2]] = mem_wdata;
            if (exp_q.size() == 0) exp_busy = 0;
          end else begin
            rd_data = mem[mem_addr[11:2]];
            rd_pend = 1;
          end
        end
      end
      if (reg_we && !cur_busy) model_write(reg_addr, reg_wdata);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    while (exp_busy || exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [31:0] s, input logic [31:0] d,
                        input logic [31:0] sz, input logic [31:0] ctl);
    wr(3'd0, s);
    wr(3'd1, d);
    wr(3'd2, sz);
    wr(3'd3, ctl);
    wait_idle();
  endtask

  initial begin
    #(8 * 100000);
    chk(0, "R8", "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int mism;
    for (int k = 0; k < 1024; k++) begin
      mem[k]     = 32'(k) * 32'h01010101 ^ 32'h5A00_00A5;
      ref_mem[k] = mem[k];
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1: reset state
    @(negedge clk);
    chk(!busy && !mem_valid, "R1", "idle after reset", {busy, mem_valid}, 0);
    rd(3'd6, v); chk(v == 0, "R1", "base after reset", v, 0);
    rd(3'd3, v); chk(v == 0, "R1", "control after reset", v, 0);

    wr(3'd6, 32'h0000_0100);
    wr(3'd5, {16'd64, 16'd64});
    wr(3'd4, 32'hCAFE_0001);

    // R3: fill 3x2 at (2,1)
    run_op(0, {16'd2, 16'd1}, {16'd3, 16'd2}, 32'h8001_000C);
    // R6: low half kept, upper half not stored
    rd(3'd3, v); chk(v == 32'h0000_000C, "R6", "control readback", v, 32'h0000_000C);

    // R3: single pixel fill
    run_op(0, {16'd15, 16'd15}, {16'd1, 16'd1}, 32'h8001_0000);

    // R7 / R9: writes during a running fill
    wr(3'd0, 0); wr(3'd1, {16'd8, 16'd8}); wr(3'd2, {16'd4, 16'd4});
    wr(3'd3, 32'h8001_000C);
    wr(3'd4, 32'hDEAD_BEEF);
    wr(3'd3, 32'h8000_1234);
    rd(3'd7, v); chk(v[3] == 1'b1, "R9", "status busy bit while running", v, 32'h8);
    wait_idle();
    rd(3'd4, v); chk(v == 32'hCAFE_0001, "R7", "colour after write while busy", v, 32'hCAFE_0001);
    rd(3'd3, v); chk(v == 32'h0000_000C, "R7", "control after write while busy", v, 32'h0000_000C);
    rd(3'd7, v); chk(v == 0, "R9", "status idle", v, 0);

    // R4: forward copy, no overlap
    run_op({16'd0, 16'd4}, {16'd5, 16'd6}, {16'd4, 16'd3}, 32'h8000_000C);
    // R5: destination below-right, reverse from corners
    run_op({16'd4, 16'd4}, {16'd5, 16'd5}, {16'd4, 16'd4}, 32'h8800_000C);
    // R4: destination above-left, forward
    run_op({16'd3, 16'd3}, {16'd1, 16'd2}, {16'd4, 16'd3}, 32'h8000_000C);
    // R5: same row, shift right, reverse
    run_op({16'd4, 16'd10}, {16'd6, 16'd10}, {16'd5, 16'd1}, 32'h8800_000C);

    // R10: unknown command and zero size do not start
    wr(3'd2, {16'd3, 16'd2});
    wr(3'd3, 32'h8002_000C);
    rd(3'd7, v); chk(v == 0, "R10", "unknown command started", v, 0);
    wr(3'd2, {16'd0, 16'd2});
    wr(3'd3, 32'h8001_000C);
    rd(3'd7, v); chk(v == 0, "R10", "zero width started", v, 0);
    repeat (4) @(negedge clk);

    // R2: final frame buffer image
    mism = 0;
    for (int k = 0; k < 1024; k++) if (mem[k] !== ref_mem[k]) mism++;
    chk(mism == 0, "R2", "memory image mismatches", 32'(mism), 0);
    finish_run();
  end

endmodule